// File: doc/BRIEF.md
# Tunable Pseudo-Random Press Generator

This block stands in for a human player's button. It produces a stream of pseudo-random "press" decisions whose average rate follows a 9-bit difficulty setting. A 10-bit shift register with XNOR feedback supplies a new pseudo-random value on every enable tick. An unsigned magnitude comparator checks the zero-extended setting against that value. A press is registered whenever the setting is strictly larger.

All state sits in one clock domain. A separate clock-enable tick, produced elsewhere from the system clock at a few hundred hertz, sets the rate at which the block advances. Raising the setting raises the chance of a press on each tick. A setting of zero silences the generator entirely. The raw register value is brought out so that other logic or an observer can follow the sequence.

Top module: `cyber_press_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) leaves `lfsr_q` = 10'h000 and `press` = 0 after that edge.
- R2: On a clock edge where `tick` is 0 and `rst` is 0, both `lfsr_q` and `press` keep their values.
- R3: On a clock edge where `tick` is 1, the register shifts toward the MSB. The new `lfsr_q[9:1]` equals the old `lfsr_q[8:0]`, and the new `lfsr_q[0]` equals the XNOR of the old `lfsr_q[9]` and `lfsr_q[6]`.
- R4: `lfsr_q` never takes the value 10'h3FF.
- R5: Counting from reset, `lfsr_q` first returns to 10'h000 after exactly 1023 ticks, and it is 0 only on tick counts that are multiples of 1023.
- R6: On a tick, `press` is loaded with 1 exactly when `{1'b0, level}` is unsigned-greater than the new `lfsr_q` value. It is loaded with 0 otherwise. The pair (`press`, `lfsr_q`) is therefore consistent between ticks.
- R7: A tick with `level` = 0 always loads `press` = 0.
- R8: A tick where `{1'b0, level}` equals the new `lfsr_q` loads `press` = 0. If it exceeds that value by one, the tick loads 1.
- R9: Whenever `lfsr_q[9]` is 1, `press` is 0, because the extended setting never exceeds 511.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for all state |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Clock enable; the block advances only when high |
| level | input | 9 | Difficulty setting, unsigned |
| press | output | 1 | Registered press decision |
| lfsr_q | output | 10 | Current pseudo-random register value |

## Verification
The bench aims at the comparator boundaries. It drives the setting equal to the new register value and one above it: a design that tests greater-or-equal would press on the equal case, and a design that loses the carry of a lower bit would miss the one-above case. It drives a setting of zero and register values with the top bit set, where a sign-extended or wrongly extended operand would produce spurious presses. It runs a full 1023-tick cycle and checks the return to zero. Wrong taps or OR-style feedback would either lock up at all ones or return early. Idle gaps between ticks and a mid-run reset catch a register that advances without an enable or fails to clear.

// File: rtl/cpg_pkg.sv
package cpg_pkg;
    // Register width and feedback taps (1-indexed stage numbers).
    parameter int CPG_W     = 10;
    parameter int CPG_TAP_A = 10;
    parameter int CPG_TAP_B = 7;
endpackage

// File: rtl/cpg_lfsr.sv
module cpg_lfsr #(
    parameter int W     = cpg_pkg::CPG_W,
    parameter int TAP_A = cpg_pkg::CPG_TAP_A,
    parameter int TAP_B = cpg_pkg::CPG_TAP_B
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [W-1:0] q,
    output logic [W-1:0] q_next
);
    localparam int IA = TAP_A - 1;
    localparam int IB = TAP_B - 1;

    logic fb;

    // XNOR feedback: all-zeros is a legal start, all-ones is the trap state.
    always_comb begin
        fb     = ~(q[IA] ^ q[IB]);
        q_next = {q[W-2:0], fb};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (adv) begin
            q <= q_next;
        end
    end
endmodule

// File: rtl/cpg_mag_cmp.sv
module cpg_mag_cmp #(
    parameter int W = cpg_pkg::CPG_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         a_gt_b
);
    // Ripple from MSB: greater is decided at the highest differing bit.
    logic [W:0] gt_c;
    logic [W:0] eq_c;

    assign gt_c[W] = 1'b0;
    assign eq_c[W] = 1'b1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign gt_c[i] = gt_c[i+1] | (eq_c[i+1] & a[i] & ~b[i]);
        assign eq_c[i] = eq_c[i+1] & ~(a[i] ^ b[i]);
    end

    assign a_gt_b = gt_c[0];
endmodule

// File: rtl/cyber_press_gen.sv
module cyber_press_gen #(
    parameter int W     = cpg_pkg::CPG_W,
    parameter int TAP_A = cpg_pkg::CPG_TAP_A,
    parameter int TAP_B = cpg_pkg::CPG_TAP_B
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  logic [W-2:0]   level,
    output logic           press,
    output logic [W-1:0]   lfsr_q
);
    localparam int LVL_W = W - 1;
    localparam int PAD_W = W - LVL_W;

    logic [W-1:0] lfsr_nxt;
    logic [W-1:0] level_ext;
    logic         hit;

    assign level_ext = {{PAD_W{1'b0}}, level};

    cpg_lfsr #(.W(W), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_lfsr (
        .clk    (clk),
        .rst    (rst),
        .adv    (tick),
        .q      (lfsr_q),
        .q_next (lfsr_nxt)
    );

    // Compare against the value being loaded so press and lfsr_q stay paired.
    cpg_mag_cmp #(.W(W)) u_cmp (
        .a      (level_ext),
        .b      (lfsr_nxt),
        .a_gt_b (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            press <= 1'b0;
        end else if (tick) begin
            press <= hit;
        end
    end
endmodule

// File: rtl/cpg_checker.sv
module cpg_checker #(
    parameter int W = cpg_pkg::CPG_W
) (
    input logic         clk,
    input logic         rst,
    input logic         tick,
    input logic [W-2:0] level,
    input logic         press,
    input logic [W-1:0] lfsr_q
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (lfsr_q == '0) && !press);

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(lfsr_q) && $stable(press));

    assert_shift_R3: assert property (@(posedge clk) disable iff (rst)
        tick |=> lfsr_q[W-1:1] == $past(lfsr_q[W-2:0]));

    assert_feedback_R3: assert property (@(posedge clk) disable iff (rst)
        tick |=> lfsr_q[0] == ~($past(lfsr_q[9]) ^ $past(lfsr_q[6])));

    assert_no_lockup_R4: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '1);

    assert_press_R6: assert property (@(posedge clk) disable iff (rst)
        tick |=> press == ({1'b0, $past(level)} > lfsr_q));

    assert_zero_level_R7: assert property (@(posedge clk) disable iff (rst)
        (tick && level == '0) |=> !press);

    assert_high_value_R9: assert property (@(posedge clk) disable iff (rst)
        lfsr_q[W-1] |-> !press);
endmodule

bind cyber_press_gen cpg_checker #(.W(W)) u_cpg_checker (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .level  (level),
    .press  (press),
    .lfsr_q (lfsr_q)
);

// File: tb/cyber_press_gen_tb.sv
module cyber_press_gen_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [8:0] level = '0;
    logic       press;
    logic [9:0] lfsr_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [9:0]  lfsr;
        logic        press;
        logic [8:0]  level;
        logic [15:0] cnt;
    } exp_t;

    exp_t       sb_q[$];
    logic [9:0] model = '0;
    int         tick_cnt = 0;
    logic [9:0] last_lfsr = '0;
    logic       last_press = 1'b0;

    always #10 clk = ~clk;

    cyber_press_gen u_dut (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .level  (level),
        .press  (press),
        .lfsr_q (lfsr_q)
    );

    function automatic logic [9:0] step(input logic [9:0] v);
        return {v[8:0], ~(v[9] ^ v[6])};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Driver: one tick with a level chosen relative to the next value.
    task automatic drive_tick(input int mode, input int seed);
        logic [9:0] nxt;
        logic [8:0] lv;
        exp_t it;
        @(negedge clk);
        nxt = step(model);
        case (mode)
            0: lv = 9'd0;
            1: lv = 9'h1FF;
            2: lv = (nxt < 10'd512) ? nxt[8:0] : 9'h1FF;
            3: lv = (nxt < 10'd511) ? 9'(nxt + 10'd1) : 9'd0;
            default: lv = 9'(seed * 37 + 11);
        endcase
        model = nxt;
        tick_cnt++;
        it.lfsr  = nxt;
        it.press = ({1'b0, lv} > nxt);
        it.level = lv;
        it.cnt   = 16'(tick_cnt);
        sb_q.push_back(it);
        level = lv;
        tick  = 1'b1;
    endtask

    task automatic idle(input int n, input logic [8:0] lv);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick  = 1'b0;
            level = lv;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        tick = 1'b0;
        rst  = 1'b1;
        sb_q.delete();
        model    = '0;
        tick_cnt = 0;
        @(negedge clk);
        chk("R1 lfsr after reset", 16'(lfsr_q), 16'h0);
        chk("R1 press after reset", 16'(press), 16'h0);
        rst = 1'b0;
    endtask

    // Monitor: pops expected items after ticked edges, checks holds otherwise.
    always @(posedge clk) begin
        logic was_tick, was_rst;
        exp_t it;
        string tg;
        was_tick = tick;
        was_rst  = rst;
        #2;
        if (was_rst) begin
            last_lfsr  = '0;
            last_press = 1'b0;
        end else if (was_tick) begin
            if (sb_q.size() == 0) begin
                chk("scoreboard underflow", 16'h1, 16'h0);
            end else begin
                it = sb_q.pop_front();
                chk("R3 lfsr step", 16'(lfsr_q), 16'(it.lfsr));
                if (it.level == 9'd0)                      tg = "R7 press zero level";
                else if (it.lfsr >= 10'd512)               tg = "R9 press high value";
                else if ({1'b0, it.level} == it.lfsr)      tg = "R8 press equal";
                else if ({1'b0, it.level} == it.lfsr + 1)  tg = "R8 press one above";
                else                                       tg = "R6 press compare";
                chk(tg, 16'(press), 16'(it.press));
                chk("R4 no all-ones", 16'(lfsr_q == 10'h3FF), 16'h0);
                if (lfsr_q == 10'h0)
                    chk("R5 zero only at period", 16'(it.cnt % 1023), 16'h0);
                if (it.cnt == 16'd1023)
                    chk("R5 zero at 1023", 16'(lfsr_q), 16'h0);
            end
            last_lfsr  = lfsr_q;
            last_press = press;
        end else begin
            chk("R2 lfsr hold", 16'(lfsr_q), 16'(last_lfsr));
            chk("R2 press hold", 16'(press), 16'(last_press));
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 lfsr after reset", 16'(lfsr_q), 16'h0);
        chk("R1 press after reset", 16'(press), 16'h0);
        rst = 1'b0;
        idle(5, 9'h1FF);
        for (int i = 0; i < 1030; i++) begin
            drive_tick(i % 5, i);
            if (i % 7 == 3) idle(2, 9'(i));
        end
        idle(3, 9'd0);
        do_reset();
        for (int i = 0; i < 60; i++) begin
            drive_tick((i + 2) % 5, i * 3);
        end
        idle(4, 9'h155);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule